// File: doc/BRIEF.md
# Change-of-State Digital Input Port

This block is a read-only peripheral that presents 48 digital input lines to a host bus. It exposes them as six byte-wide groups inside an 8-byte register window. Each raw line is first brought into the clock domain through a two-flop synchronizer. The synchronized value is then compared with its value one clock earlier, so that a change on any line of a group can be detected.

Software picks which groups may raise an interrupt by writing a 6-bit enable mask to the control byte at offset 7. A level change in either direction on any line of an enabled group latches that group's status bit. While any status bit of an enabled group is set, a level interrupt output stays asserted, which makes it suitable for a shared interrupt line. Reading the control byte returns the group status and an active-low pending flag. The same read clears the latched status.

There are no outputs and no direction control: every line is always an input.

Top module: `cos_input_port`

## Requirements
- R1: A read of offset 0, 1 or 2 returns groups 0, 1 or 2, and a read of offset 4, 5 or 6 returns groups 3, 4 or 5. Bit n of the returned byte is input line group*8+n, taken from its synchronized value. A pin change becomes visible in the read data after the second rising clock edge that follows it.
- R2: A read of offset 3 returns 0x00.
- R3: A write to offset 7 loads write-data bits 5..0 into the group enable mask, with bit k enabling group k. Write-data bits 7..6 are ignored.
- R4: A read of offset 7 returns the latched group status in bits 5..0 and always returns 0 in bit 7.
- R5: A rising or falling change on any line of an enabled group sets that group's status bit. The bit is readable after the third rising clock edge that follows the pin change.
- R6: `irq_o` is high exactly while some enabled group has its status bit set. Bit 6 of the offset-7 read value is the inverse of `irq_o`: it reads 0 when an interrupt is pending and 1 when none is pending.
- R7: Reading offset 7 clears all status bits, which deasserts `irq_o`. A change that is detected on the same clock edge as that read is latched, not lost.
- R8: A group whose enable bit is 0 never sets its status bit. Enabling a group whose lines are steady produces no event.
- R9: Writes to offsets 0..6 change nothing. Reads of offsets 0..6 leave the status and `irq_o` unchanged.
- R10: After reset the enable mask and the status are zero and `irq_o` is low.
- R11: Writing 0 to offset 7 and then reading offset 7 leaves `irq_o` low. It stays low through later pin changes on any group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_i | input | 48 | Raw asynchronous input lines |
| bus_addr_i | input | 3 | Byte offset within the register window |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while `bus_rd_i` is high |
| irq_o | output | 1 | Level interrupt request, active high |

## Verification
The assertions take for granted that each bus strobe lasts exactly one cycle and that read and write never occur in the same cycle. The bench keeps to this by driving every access at a falling edge and holding it for only one cycle. The assertions also assume that the pins are steady around the release of reset. The bench keeps the pins at zero until reset has been released, and after that changes them only at falling edges, and only from one scenario task at a time.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int WIN_AW   = 3;
  localparam int BYTE_W   = 8;
  localparam logic [WIN_AW-1:0] CTRL_OFS = 3'd7;
  localparam logic [WIN_AW-1:0] GAP_OFS  = 3'd3;
  localparam int PEND_BIT = 6;

  typedef struct packed {
    logic              hit;
    logic [WIN_AW-1:0] grp;
  } grp_sel_t;

  // Window offset to input group: offsets below the gap map directly,
  // offsets above it are shifted down by one.
  function automatic grp_sel_t offset_to_group(input logic [WIN_AW-1:0] ofs);
    grp_sel_t s;
    s.hit = (ofs != GAP_OFS) && (ofs != CTRL_OFS);
    s.grp = (ofs < GAP_OFS) ? ofs : ofs - 3'd1;
    return s;
  endfunction

  // Control byte as seen on a read: status in the low bits,
  // active-low pending flag, top bit zero.
  function automatic logic [BYTE_W-1:0] ctrl_word(input logic [5:0] status,
                                                  input logic       irq);
    logic [BYTE_W-1:0] w;
    w           = '0;
    w[5:0]      = status;
    w[PEND_BIT] = ~irq;
    return w;
  endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= async_i;
        else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cos_change_latch.sv
module cos_change_latch #(
  parameter int NUM_GROUPS = 6,
  parameter int GROUP_W    = 8,
  localparam int PIN_W     = NUM_GROUPS * GROUP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [PIN_W-1:0]      sync_i,
  input  logic [NUM_GROUPS-1:0] en_i,
  input  logic                  clr_i,
  output logic [NUM_GROUPS-1:0] evt_o,
  output logic [NUM_GROUPS-1:0] status_o
);
  logic [PIN_W-1:0]      prev_q;
  logic [NUM_GROUPS-1:0] grp_chg;
  logic [NUM_GROUPS-1:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sync_i;
  end

  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
      assign grp_chg[g] = |(sync_i[g*GROUP_W +: GROUP_W] ^ prev_q[g*GROUP_W +: GROUP_W]);
    end
  endgenerate

  // Only enabled groups report; enable state never feeds the comparison.
  assign evt_o = grp_chg & en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (clr_i ? '0 : status_q) | evt_o;
  end

  assign status_o = status_q;
endmodule

// File: rtl/cos_bus_regs.sv
module cos_bus_regs
  import cos_pkg::*;
#(
  parameter int NUM_GROUPS = 6,
  parameter int GROUP_W    = 8,
  localparam int PIN_W     = NUM_GROUPS * GROUP_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [WIN_AW-1:0]     addr_i,
  input  logic                  rd_i,
  input  logic                  wr_i,
  input  logic [BYTE_W-1:0]     wdata_i,
  input  logic [PIN_W-1:0]      sync_i,
  input  logic [NUM_GROUPS-1:0] status_i,
  input  logic                  irq_i,
  output logic [NUM_GROUPS-1:0] en_o,
  output logic                  clr_o,
  output logic [BYTE_W-1:0]     rdata_o
);
  logic [NUM_GROUPS-1:0] en_q;
  logic                  ctrl_hit;
  grp_sel_t              sel;
  logic [5:0]            status_w;
  logic                  unused_wbits;

  assign ctrl_hit     = (addr_i == CTRL_OFS);
  assign sel          = offset_to_group(addr_i);
  assign unused_wbits = ^wdata_i[BYTE_W-1:NUM_GROUPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 en_q <= '0;
    else if (wr_i && ctrl_hit)  en_q <= wdata_i[NUM_GROUPS-1:0];
  end

  assign en_o  = en_q;
  assign clr_o = rd_i && ctrl_hit;

  always_comb begin
    status_w                 = '0;
    status_w[NUM_GROUPS-1:0] = status_i;
  end

  always_comb begin
    rdata_o = '0;
    if (ctrl_hit) begin
      rdata_o = ctrl_word(status_w, irq_i);
    end else if (sel.hit) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (sel.grp == WIN_AW'(g)) rdata_o = sync_i[g*GROUP_W +: GROUP_W];
      end
    end
  end
endmodule

// File: rtl/cos_input_port.sv
module cos_input_port #(
  parameter int NUM_GROUPS  = 6,
  parameter int GROUP_W     = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PIN_W      = NUM_GROUPS * GROUP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PIN_W-1:0]  pins_i,
  input  logic [2:0]        bus_addr_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              irq_o
);
  logic [PIN_W-1:0]      pins_sync;
  logic [NUM_GROUPS-1:0] grp_en;
  logic [NUM_GROUPS-1:0] grp_evt;
  logic [NUM_GROUPS-1:0] grp_status;
  logic                  status_clr;

  cos_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pins_i),
    .sync_o  (pins_sync)
  );

  cos_change_latch #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_i   (pins_sync),
    .en_i     (grp_en),
    .clr_i    (status_clr),
    .evt_o    (grp_evt),
    .status_o (grp_status)
  );

  assign irq_o = |(grp_status & grp_en);

  cos_bus_regs #(.NUM_GROUPS(NUM_GROUPS), .GROUP_W(GROUP_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_i   (bus_addr_i),
    .rd_i     (bus_rd_i),
    .wr_i     (bus_wr_i),
    .wdata_i  (bus_wdata_i),
    .sync_i   (pins_sync),
    .status_i (grp_status),
    .irq_i    (irq_o),
    .en_o     (grp_en),
    .clr_o    (status_clr),
    .rdata_o  (bus_rdata_o)
  );
endmodule

// File: rtl/cos_input_port_checker.sv
module cos_input_port_checker #(
  parameter int NUM_GROUPS = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            bus_addr_i,
  input logic                  bus_rd_i,
  input logic                  bus_wr_i,
  input logic [7:0]            bus_rdata_o,
  input logic                  irq_o,
  input logic [NUM_GROUPS-1:0] en_i,
  input logic [NUM_GROUPS-1:0] evt_i,
  input logic [NUM_GROUPS-1:0] status_i,
  input logic                  clr_i
);
  AST_NEW_BITS_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_i & ~$past(status_i) & ~$past(en_i)) == '0)); // R8

  AST_READ_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && (evt_i == '0)) |=> (status_i == '0)); // R7

  AST_EVENT_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != '0) |=> ((status_i & $past(evt_i)) == $past(evt_i))); // R7

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !clr_i && !bus_wr_i) |=> irq_o); // R6

  AST_FLAG_INVERTS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == 3'd7) |-> (bus_rdata_o[6] == !irq_o)); // R6

  AST_OTHER_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr_i && bus_addr_i != 3'd7) |=> $stable(en_i)); // R9

  AST_GAP_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && bus_addr_i == 3'd3) |-> (bus_rdata_o == 8'h00)); // R2
endmodule

bind cos_input_port cos_input_port_checker #(.NUM_GROUPS(NUM_GROUPS)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_addr_i  (bus_addr_i),
  .bus_rd_i    (bus_rd_i),
  .bus_wr_i    (bus_wr_i),
  .bus_rdata_o (bus_rdata_o),
  .irq_o       (irq_o),
  .en_i        (grp_en),
  .evt_i       (grp_evt),
  .status_i    (grp_status),
  .clr_i       (status_clr)
);

// File: tb/cos_input_port_bench.sv
`timescale 1ns/1ps
module cos_input_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] pins = '0;
  logic [2:0]  addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cos_input_port u_cos_input_port (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .bus_addr_i(addr),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic set_pins(input logic [47:0] v);
    @(negedge clk); pins = v;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    @(negedge clk);
    chk("R10 irq after reset", 64'(irq), 64'h0);
    bus_read(3'd7, d);
    chk("R10 ctrl after reset", 64'(d), 64'h40);
  endtask

  task automatic t_group_map();
    logic [7:0] d;
    logic [47:0] pat = 48'hA1B2C3D4E5F6;
    set_pins(pat);
    @(posedge clk); @(posedge clk); @(negedge clk);
    bus_read(3'd0, d); chk("R1 offset0 after two edges", 64'(d), 64'hF6);
    bus_read(3'd1, d); chk("R1 offset1", 64'(d), 64'hE5);
    bus_read(3'd2, d); chk("R1 offset2", 64'(d), 64'hD4);
    bus_read(3'd3, d); chk("R2 gap offset", 64'(d), 64'h00);
    bus_read(3'd4, d); chk("R1 offset4", 64'(d), 64'hC3);
    bus_read(3'd5, d); chk("R1 offset5", 64'(d), 64'hB2);
    bus_read(3'd6, d); chk("R1 offset6", 64'(d), 64'hA1);
    bus_read(3'd7, d); chk("R8 disabled groups silent", 64'(d), 64'h40);
  endtask

  task automatic t_enable_quiet();
    logic [7:0] d;
    bus_write(3'd7, 8'hFF);
    settle();
    chk("R8 enable makes no event irq", 64'(irq), 64'h0);
    bus_read(3'd7, d);
    chk("R3 R4 enable with steady pins", 64'(d), 64'h40);
  endtask

  task automatic t_both_edges();
    logic [7:0] d;
    set_pins(pins ^ 48'h0000_0000_0200);
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R5 not yet after two edges", 64'(irq), 64'h0);
    @(posedge clk); @(negedge clk);
    chk("R6 irq after three edges", 64'(irq), 64'h1);
    bus_read(3'd7, d);
    chk("R5 status group1 edge", 64'(d), 64'h02);
    chk("R7 irq cleared by read", 64'(irq), 64'h0);
    bus_read(3'd7, d);
    chk("R7 status cleared", 64'(d), 64'h40);
    set_pins(pins ^ 48'h0000_0000_0200);
    settle();
    bus_read(3'd7, d);
    chk("R5 opposite edge", 64'(d), 64'h02);
  endtask

  task automatic t_disabled_group();
    logic [7:0] d;
    bus_write(3'd7, 8'h01);
    set_pins(pins ^ 48'h0100_0000_0000);
    settle();
    chk("R8 disabled group irq", 64'(irq), 64'h0);
    bus_read(3'd7, d);
    chk("R8 disabled group status", 64'(d), 64'h40);
    set_pins(pins ^ 48'h0000_0000_0008);
    settle();
    bus_read(3'd7, d);
    chk("R3 only group0 enabled", 64'(d), 64'h01);
  endtask

  task automatic t_other_access();
    logic [7:0] d;
    bus_write(3'd2, 8'h00);
    bus_write(3'd3, 8'h00);
    bus_write(3'd0, 8'h00);
    set_pins(pins ^ 48'h0000_0000_0001);
    settle();
    for (int a = 0; a < 7; a++) bus_read(3'(a), d);
    chk("R9 irq kept after data reads", 64'(irq), 64'h1);
    bus_read(3'd7, d);
    chk("R9 enable kept and status kept", 64'(d), 64'h01);
  endtask

  task automatic t_same_cycle();
    logic [7:0] d;
    bus_write(3'd7, 8'h3F);
    set_pins(pins ^ 48'h0000_0000_0010);
    settle();
    set_pins(pins ^ 48'h0000_0040_0000);
    @(posedge clk); @(posedge clk);
    bus_read(3'd7, d);
    chk("R7 read during new event", 64'(d), 64'h01);
    chk("R7 new event keeps irq", 64'(irq), 64'h1);
    bus_read(3'd7, d);
    chk("R7 event kept", 64'(d), 64'h04);
  endtask

  task automatic t_disable_seq();
    logic [7:0] d;
    bus_write(3'd7, 8'h01);
    set_pins(pins ^ 48'h0000_0000_0080);
    settle();
    chk("R6 pending before disable", 64'(irq), 64'h1);
    bus_write(3'd7, 8'h00);
    bus_read(3'd7, d);
    chk("R11 read after zero write", 64'(d), 64'h41);
    chk("R11 irq low", 64'(irq), 64'h0);
    set_pins(~pins);
    settle();
    chk("R11 irq stays low", 64'(irq), 64'h0);
    bus_read(3'd7, d);
    chk("R11 no status after disable", 64'(d), 64'h40);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_group_map();
    t_enable_quiet();
    t_both_edges();
    t_disabled_group();
    t_other_access();
    t_same_cycle();
    t_disable_seq();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule